// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps wall-clock time and date as eight packed-BCD byte registers: seconds, minutes, hours (24-hour), day of week, date, month, year and century. A one-cycle `sec_tick` pulse advances the time by one second. The carries ripple through all eight fields, with the month length and leap year taken into account.

Software reaches the fields over a byte-wide synchronous bus. Reads are combinational from the address. Writes take effect at the clock edge. A control register carries a transfer-enable bit. Clearing that bit freezes the visible copy of the time so that a multi-byte read is coherent; the internal counters keep running during the freeze. Fields written while frozen collect in the visible copy. When transfer enable is set again, those written fields are loaded into the counters, and every field that was not written keeps its counted value.

Top module: `bcd_calendar_regs`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00, day of week 0x01, date 0x01, month 0x01, year 0x00 and century 0x20. The control register (offset 0xF) reads 0x80.
- R2: Field offsets are: seconds 0x0, minutes 0x1, hours 0x2, day of week 0x3, date 0x4, month 0x5, year 0x6, century 0x7. A tick counts seconds and minutes in BCD 00..59 and hours in BCD 00..23, each carrying into the next field on wrap.
- R3: A carry out of hours advances the day of week 1..7, wrapping 7 to 1, and advances the date.
- R4: The date wraps to 01 and carries into the month after 30 in months 04, 06, 09 and 11, and after 31 in the other months except February.
- R5: February ends at 29 when the BCD year is a multiple of four (00 counts), otherwise at 28.
- R6: Month wraps 12 to 01 and carries into the year. Year wraps 99 to 00 and carries into the century.
- R7: Written values are masked to the field width: seconds and minutes keep bits 6:0, hours and date keep bits 5:0, day of week keeps bits 2:0, month keeps bits 4:0, and year and century keep all 8 bits.
- R8: Bits 7:5 of the month register are plain storage. They read back as written and counting leaves them unchanged.
- R9: While control bit 7 (transfer enable) is 0, ticks do not change any value read from offsets 0x0..0x7, and a write to a field reads back at once.
- R10: Writing control bit 7 from 0 to 1 loads the fields written during the freeze into the counters. Unwritten fields show the time counted through the freeze, including ticks seen while frozen.
- R11: Control bit 5 is a plain read/write bit. The other control bits (6, 4:0) read 0. Offsets 0x8..0xE read 0 and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |

## Verification
The embedded assertions check, on every cycle:
- the seconds wrap from 59 to 00;
- that the visible copy stays still while frozen and no write arrives;
- that the internal seconds counter keeps moving on every tick during a freeze;
- that a written seconds field is committed into the counter when transfer enable rises.

Only the directed scenarios can show:
- the calendar-level carries (month lengths, leap-year February, year-to-century);
- write masking and the spare month bits;
- the mix of written and counted fields after a commit.

The calendar carries need specific preloaded dates and would be awkward to express as properties.

// File: rtl/bcd_calendar_regs.sv
module bcd_calendar_regs #(
  parameter logic [7:0] RST_CENTURY = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sec_tick,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int NF = 8;
  localparam logic [3:0] CTL_ADDR = 4'hF;
  localparam logic [NF-1:0][7:0] FMASK =
    {8'hFF, 8'hFF, 8'h1F, 8'h3F, 8'h07, 8'h3F, 8'h7F, 8'h7F};
  localparam logic [NF-1:0][7:0] RST_VAL =
    {RST_CENTURY, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  logic [NF-1:0][7:0] cnt, hold, nxt;
  logic [NF-1:0]      dirty;
  logic               te, bme;
  logic [2:0]         mon_hi;

  wire [2:0] fidx   = bus_addr[2:0];
  wire       fld_wr = bus_wr && !bus_addr[3];
  wire       ctl_wr = bus_wr && (bus_addr == CTL_ADDR);
  wire       commit = ctl_wr && !te && bus_wdata[7];

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [7:0] month_end(input logic [7:0] m, input logic [7:0] y);
    logic leap;
    leap = y[4] ? (y[3:0] == 4'd2 || y[3:0] == 4'd6)
                : (y[3:0] == 4'd0 || y[3:0] == 4'd4 || y[3:0] == 4'd8);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  always_comb begin
    logic c;
    c   = 1'b0;
    nxt = cnt;
    if (sec_tick) begin
      c = (cnt[0] == 8'h59);
      nxt[0] = c ? 8'h00 : bcd_inc(cnt[0]);
      if (c) begin
        c = (cnt[1] == 8'h59);
        nxt[1] = c ? 8'h00 : bcd_inc(cnt[1]);
      end
      if (c) begin
        c = (cnt[2] == 8'h23);
        nxt[2] = c ? 8'h00 : bcd_inc(cnt[2]);
      end
      if (c) begin
        nxt[3] = (cnt[3] >= 8'h07) ? 8'h01 : cnt[3] + 8'd1;
        c = (cnt[4] >= month_end(cnt[5], cnt[6]));
        nxt[4] = c ? 8'h01 : bcd_inc(cnt[4]);
      end
      if (c) begin
        c = (cnt[5] >= 8'h12);
        nxt[5] = c ? 8'h01 : bcd_inc(cnt[5]);
      end
      if (c) begin
        c = (cnt[6] == 8'h99);
        nxt[6] = c ? 8'h00 : bcd_inc(cnt[6]);
      end
      if (c) nxt[7] = (cnt[7] == 8'h99) ? 8'h00 : bcd_inc(cnt[7]);
    end
    if (commit) begin
      for (int i = 0; i < NF; i++)
        if (dirty[i]) nxt[i] = hold[i];
    end else if (fld_wr && te) begin
      nxt[fidx] = bus_wdata & FMASK[fidx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= RST_VAL;
      hold   <= RST_VAL;
      dirty  <= '0;
      te     <= 1'b1;
      bme    <= 1'b0;
      mon_hi <= 3'd0;
    end else begin
      cnt <= nxt;
      if (te || commit) hold <= nxt;
      else if (fld_wr) hold[fidx] <= bus_wdata & FMASK[fidx];
      if (commit) dirty <= '0;
      else if (!te && fld_wr) dirty[fidx] <= 1'b1;
      if (ctl_wr) begin
        te  <= bus_wdata[7];
        bme <= bus_wdata[5];
      end
      if (fld_wr && fidx == 3'd5) mon_hi <= bus_wdata[7:5];
    end
  end

  assign bus_rdata = !bus_addr[3] ? ((fidx == 3'd5) ? {mon_hi, hold[5][4:0]} : hold[fidx])
                   : (bus_addr == CTL_ADDR) ? {te, 1'b0, bme, 5'b0} : 8'h00;

  a_r2_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (te && sec_tick && !bus_wr && hold[0] == 8'h59) |=> (hold[0] == 8'h00));

  a_r9_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !bus_wr) |=> $stable(hold));

  a_r9_counts_while_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && sec_tick && !ctl_wr) |=> (cnt[0] != $past(cnt[0])));

  a_r10_commit_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && dirty[0]) |=> (cnt[0] == $past(hold[0])));
endmodule

// File: tb/bcd_calendar_regs_tb_top.sv
module bcd_calendar_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [3:0] bus_addr = 4'h0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  bcd_calendar_regs dut_i (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic chk(input string req, input logic [3:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    n_chk++;
    if (bus_rdata !== exp) begin
      n_bad++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic set_time(input logic [7:0] s, m, h, w, d, mo, y, c);
    wr(4'h0, s); wr(4'h1, m); wr(4'h2, h); wr(4'h3, w);
    wr(4'h4, d); wr(4'h5, mo); wr(4'h6, y); wr(4'h7, c);
  endtask

  task automatic t_reset();
    chk("R1", 4'h0, 8'h00); chk("R1", 4'h1, 8'h00); chk("R1", 4'h2, 8'h00);
    chk("R1", 4'h3, 8'h01); chk("R1", 4'h4, 8'h01); chk("R1", 4'h5, 8'h01);
    chk("R1", 4'h6, 8'h00); chk("R1", 4'h7, 8'h20); chk("R1", 4'hF, 8'h80);
  endtask

  task automatic t_day_carry();
    set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h15, 8'h03, 8'h24, 8'h20);
    tick();
    chk("R2", 4'h0, 8'h00); chk("R2", 4'h1, 8'h00); chk("R2", 4'h2, 8'h00);
    chk("R3", 4'h3, 8'h01); chk("R3", 4'h4, 8'h16); chk("R3", 4'h5, 8'h03);
    wr(4'h0, 8'h09); tick();
    chk("R2", 4'h0, 8'h10);
  endtask

  task automatic t_month_len();
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'hA4, 8'h24, 8'h20);
    tick();
    chk("R4", 4'h4, 8'h01); chk("R8", 4'h5, 8'hA5);
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h05, 8'h24, 8'h20);
    tick();
    chk("R4", 4'h4, 8'h31); chk("R4", 4'h5, 8'h05);
    wr(4'h0, 8'h59); wr(4'h1, 8'h59); wr(4'h2, 8'h23); tick();
    chk("R4", 4'h4, 8'h01); chk("R4", 4'h5, 8'h06);
  endtask

  task automatic t_feb();
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h12, 8'h20);
    tick();
    chk("R5", 4'h4, 8'h29); chk("R5", 4'h5, 8'h02);
    wr(4'h0, 8'h59); wr(4'h1, 8'h59); wr(4'h2, 8'h23); tick();
    chk("R5", 4'h4, 8'h01); chk("R5", 4'h5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h10, 8'h20);
    tick();
    chk("R5", 4'h4, 8'h01); chk("R5", 4'h5, 8'h03);
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h00, 8'h21);
    tick();
    chk("R5", 4'h4, 8'h29);
  endtask

  task automatic t_year();
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99, 8'h20);
    tick();
    chk("R6", 4'h4, 8'h01); chk("R6", 4'h5, 8'h01);
    chk("R6", 4'h6, 8'h00); chk("R6", 4'h7, 8'h21);
  endtask

  task automatic t_mask();
    for (int a = 0; a < 8; a++) wr(4'(a), 8'hFF);
    chk("R7", 4'h0, 8'h7F); chk("R7", 4'h1, 8'h7F); chk("R7", 4'h2, 8'h3F);
    chk("R7", 4'h3, 8'h07); chk("R7", 4'h4, 8'h3F); chk("R7", 4'h6, 8'hFF);
    chk("R8", 4'h5, 8'hFF);
  endtask

  task automatic t_freeze();
    set_time(8'h10, 8'h20, 8'h08, 8'h03, 8'h05, 8'h06, 8'h25, 8'h20);
    wr(4'hF, 8'h00);
    tick(); tick(); tick();
    chk("R9", 4'h0, 8'h10);
    wr(4'h1, 8'h45);
    chk("R9", 4'h1, 8'h45);
    tick();
    chk("R9", 4'h0, 8'h10);
    wr(4'hF, 8'h80);
    chk("R10", 4'h0, 8'h14); chk("R10", 4'h1, 8'h45);
    chk("R10", 4'h2, 8'h08); chk("R10", 4'hF, 8'h80);
    tick();
    chk("R10", 4'h0, 8'h15);
  endtask

  task automatic t_ctl();
    wr(4'hF, 8'hFF);
    chk("R11", 4'hF, 8'hA0);
    wr(4'hF, 8'h80);
    chk("R11", 4'hF, 8'h80);
    wr(4'h9, 8'h55);
    chk("R11", 4'h9, 8'h00); chk("R11", 4'h0, 8'h15); chk("R11", 4'h1, 8'h45);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_day_carry();
    t_month_len();
    t_feb();
    t_year();
    t_mask();
    t_freeze();
    t_ctl();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule